// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading two levels of page tables from memory. A translation request carries the logical address and the page-table base register value. The walker uses the upper index field to read one entry of the outer table. That entry gives the base of an inner table. The middle index field then selects the inner entry, which holds the frame number. The frame number and the untouched page offset together form the physical address.

The walker has a single memory read port with a request/response handshake and handles one walk at a time. A walk whose entry at either level is marked invalid ends with a fault instead of an address. The fault output reports which level was invalid. The result stays on the output until the requester acknowledges it. Only after that does the walker take a new request.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The logical address is split as bits 31:20 outer index, bits 19:10 inner index and bits 9:0 page offset (1 KB pages).
- R3: The first memory read goes to `ptbr + 4 * outer index`, using the `ptbr` value captured when the request was accepted. Later changes of `ptbr` have no effect on the walk in progress.
- R4: A table entry is valid when bit 0 is 1. A valid outer entry's bits 31:10, with ten zero bits appended, form the inner table base, and bits 9:1 are ignored. The second read goes to that base + 4 * inner index.
- R5: A valid inner entry ends the walk with `rsp_fault` 0 and `rsp_paddr` = {inner entry bits 31:10, logical address bits 9:0}.
- R6: An invalid outer entry ends the walk with `rsp_fault` 1, `rsp_fault_level` 0 and `rsp_paddr` 0. No second read is issued.
- R7: An invalid inner entry ends the walk with `rsp_fault` 1, `rsp_fault_level` 1 and `rsp_paddr` 0.
- R8: A memory read request holds `mem_req_valid` and a stable `mem_req_addr` until `mem_req_ready` is seen. After the handshake no further request is raised until the response for it arrives.
- R9: The result holds `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_fault_level` stable until `rsp_ready`. The cycle after the acknowledge, the walker is idle again with `req_ready` 1.
- R10: A request is accepted only while idle. `req_valid` during a walk sees `req_ready` 0 and does not change the walk's reads or result.
- R11: `mem_rsp_valid` outside the two response-wait phases is ignored, and it leaves the walker idle when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| ptbr | input | 32 | Outer table base address, sampled at acceptance |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Requester acknowledges the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_fault_level | output | 1 | Level of the invalid entry: 0 outer, 1 inner |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted read and never responds before the request handshake. They also assume that `mem_rsp_data` carries meaning only in a cycle where `mem_rsp_valid` is high. The bench models memory as a table function of the read address and serves each read from a task. That task answers once per handshake, after a chosen stall and latency, so it stays within those assumptions. The only response sent out of turn is a deliberate one while the walker is idle, to show that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // Walk phases; one walk in flight at a time.
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_OUT,
      ST_WT_OUT,
      ST_RD_IN,
      ST_WT_IN,
      ST_DONE,
      ST_FAULT
   } walk_st_e;

   localparam int ENTRY_BYTES_LOG2 = 2;

endpackage

// File: rtl/ptw_field_split.sv
module ptw_field_split #(
   parameter int ADDR_W  = 32,
   parameter int OUTER_W = 12,
   parameter int INNER_W = 10
) (
   input  logic [ADDR_W-1:0]                 vaddr,
   output logic [OUTER_W-1:0]                outer_idx,
   output logic [INNER_W-1:0]                inner_idx,
   output logic [ADDR_W-OUTER_W-INNER_W-1:0] pg_off
);
   localparam int OFF_W = ADDR_W - OUTER_W - INNER_W;

   initial begin
      assert (OFF_W > 0) else $error("field split: no offset bits left");
   end

   // R2: outer index on top, inner index next, offset at the bottom
   assign outer_idx = vaddr[ADDR_W-1 -: OUTER_W];
   assign inner_idx = vaddr[OFF_W +: INNER_W];
   assign pg_off    = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
   import ptw_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int IDX_W        = 10,
   parameter int BASE_ALIGN_W = 0
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int SPAN_W = IDX_W + ENTRY_BYTES_LOG2;

   initial begin
      assert (SPAN_W < ADDR_W) else $error("entry addr: index span too wide");
   end

   generate
      if (BASE_ALIGN_W >= SPAN_W) begin : g_merge
         // base guaranteed aligned past the table span: no carry can occur
         logic [SPAN_W-1:0] unused_low;
         assign unused_low = base[SPAN_W-1:0];
         assign addr = {base[ADDR_W-1:SPAN_W], idx, {ENTRY_BYTES_LOG2{1'b0}}};
      end else begin : g_add
         assign addr = base + {{(ADDR_W-SPAN_W){1'b0}}, idx, {ENTRY_BYTES_LOG2{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
   import ptw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     mem_req_ready,
   input  logic     mem_rsp_valid,
   input  logic     entry_ok,
   input  logic     rsp_ready,
   output walk_st_e st,
   output logic     take_req,
   output logic     take_outer,
   output logic     take_inner,
   output logic     fault_lvl
);
   walk_st_e st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:   if (req_valid)     st_nx = ST_RD_OUT;
         ST_RD_OUT: if (mem_req_ready) st_nx = ST_WT_OUT;
         ST_WT_OUT: if (mem_rsp_valid) st_nx = entry_ok ? ST_RD_IN : ST_FAULT;
         ST_RD_IN:  if (mem_req_ready) st_nx = ST_WT_IN;
         ST_WT_IN:  if (mem_rsp_valid) st_nx = entry_ok ? ST_DONE : ST_FAULT;
         ST_DONE,
         ST_FAULT:  if (rsp_ready)     st_nx = ST_IDLE;
         default:                      st_nx = ST_IDLE;
      endcase
   end

   assign take_req   = (st == ST_IDLE) && req_valid;
   assign take_outer = (st == ST_WT_OUT) && mem_rsp_valid && entry_ok;
   assign take_inner = (st == ST_WT_IN) && mem_rsp_valid && entry_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         fault_lvl <= 1'b0;
      end else begin
         st <= st_nx;
         if (mem_rsp_valid && (st == ST_WT_OUT || st == ST_WT_IN))
            fault_lvl <= (st == ST_WT_IN);
      end
   end

   AST_OUTER_BAD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WT_OUT && mem_rsp_valid && !entry_ok) |=> (st == ST_FAULT && !fault_lvl)); // R6
   AST_INNER_BAD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WT_IN && mem_rsp_valid && !entry_ok) |=> (st == ST_FAULT && fault_lvl)); // R7
   AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !req_valid) |=> (st == ST_IDLE)); // R11
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int OUTER_W      = 12,
   parameter int INNER_W      = 10,
   parameter int VALID_BIT    = 0,
   parameter int PTBR_ALIGN_W = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [ADDR_W-1:0] ptbr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_fault,
   output logic              rsp_fault_level
);
   localparam int OFF_W   = ADDR_W - OUTER_W - INNER_W;
   localparam int FRAME_W = ADDR_W - OFF_W;

   initial begin
      assert (OFF_W > 0)            else $error("walker: index fields exceed address");
      assert (VALID_BIT < OFF_W)    else $error("walker: valid bit overlaps frame field");
      assert (OUTER_W > 0 && INNER_W > 0) else $error("walker: empty index field");
   end

   walk_st_e            st;
   logic                take_req, take_outer, take_inner, fault_lvl;
   logic                entry_ok;
   logic [ADDR_W-1:0]   va_q, ptbr_q, tbl_q;
   logic [FRAME_W-1:0]  frame_q;
   logic [OUTER_W-1:0]  outer_idx;
   logic [INNER_W-1:0]  inner_idx;
   logic [OFF_W-1:0]    pg_off;
   logic [ADDR_W-1:0]   out_addr, in_addr;
   logic                unused_rsp_bits;

   assign entry_ok        = mem_rsp_data[VALID_BIT];
   assign unused_rsp_bits = ^mem_rsp_data;

   ptw_ctrl ctrl_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .entry_ok      (entry_ok),
      .rsp_ready     (rsp_ready),
      .st            (st),
      .take_req      (take_req),
      .take_outer    (take_outer),
      .take_inner    (take_inner),
      .fault_lvl     (fault_lvl)
   );

   ptw_field_split #(.ADDR_W(ADDR_W), .OUTER_W(OUTER_W), .INNER_W(INNER_W)) split_i (
      .vaddr     (va_q),
      .outer_idx (outer_idx),
      .inner_idx (inner_idx),
      .pg_off    (pg_off)
   );

   ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(OUTER_W), .BASE_ALIGN_W(PTBR_ALIGN_W)) outer_ea_i (
      .base (ptbr_q),
      .idx  (outer_idx),
      .addr (out_addr)
   );

   // inner base is only page aligned; the inner table may span several pages
   ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(INNER_W), .BASE_ALIGN_W(OFF_W)) inner_ea_i (
      .base (tbl_q),
      .idx  (inner_idx),
      .addr (in_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q    <= '0;
         ptbr_q  <= '0;
         tbl_q   <= '0;
         frame_q <= '0;
      end else begin
         if (take_req) begin
            va_q   <= req_vaddr;
            ptbr_q <= ptbr;
         end
         if (take_outer) tbl_q   <= {mem_rsp_data[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
         if (take_inner) frame_q <= mem_rsp_data[ADDR_W-1:OFF_W];
      end
   end

   assign req_ready       = (st == ST_IDLE);
   assign mem_req_valid   = (st == ST_RD_OUT) || (st == ST_RD_IN);
   assign mem_req_addr    = (st == ST_RD_IN) ? in_addr : out_addr;
   assign rsp_valid       = (st == ST_DONE) || (st == ST_FAULT);
   assign rsp_fault       = (st == ST_FAULT);
   assign rsp_fault_level = rsp_fault && fault_lvl;
   assign rsp_paddr       = (st == ST_DONE) ? {frame_q, pg_off} : '0;

   AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R8
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                     && $stable(rsp_fault_level))); // R9
   AST_ACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid)); // R9
   AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_req_valid && !req_ready)); // R10
   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_fault) |-> (rsp_paddr == '0)); // R6
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
   localparam logic [31:0] PTBR0 = 32'h0010_0000;
   localparam logic [31:0] PTBR1 = 32'h0020_0000;
   localparam logic [31:0] INNER = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, rsp_ready = 1'b0;
   logic [31:0] req_vaddr = '0, ptbr = '0, mem_rsp_data = '0;
   logic        req_ready, mem_req_valid, rsp_valid, rsp_fault, rsp_fault_level;
   logic [31:0] mem_req_addr, rsp_paddr;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ptw_walker dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .ptbr(ptbr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // table model: outer valid unless index%5==3, inner valid unless (o+i)%7==0
   function automatic bit outer_ok(input int o); return (o % 5) != 3; endfunction
   function automatic bit inner_ok(input int o, input int i); return ((o + i) % 7) != 0; endfunction
   function automatic logic [21:0] frame_of(input int o, input int i);
      return 22'((o * 1024 + i) * 13 + 5);
   endfunction

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      int o, i;
      logic [31:0] t;
      if (a >= PTBR0 && a < PTBR0 + 32'h4000) begin
         o = int'((a - PTBR0) >> 2);
         if (!outer_ok(o)) return 32'h0000_03FE;
         return (INNER + (32'(o) << 12)) | 32'h0000_02A9;   // noise in bits 9:1
      end else if (a >= INNER) begin
         t = a - INNER;
         o = int'(t >> 12);
         i = int'((t >> 2) & 32'h3FF);
         if (!inner_ok(o, i)) return 32'h0000_0154;
         return {frame_of(o, i), 10'h3C1};
      end
      return 32'h0;
   endfunction

   task automatic serve(input logic [31:0] exp_addr, input int lat, input int stall,
                        input bit busy_chk, input string req);
      int n = 0;
      logic [31:0] a;
      while (!mem_req_valid && n < 12) begin @(negedge clk); n++; end
      chk(mem_req_valid, "R8 read request raised", 32'(mem_req_valid), 32'h1);
      chk(mem_req_addr == exp_addr, req, mem_req_addr, exp_addr);
      if (busy_chk) chk(!req_ready, "R10 busy walker refuses", 32'(req_ready), 32'h0);
      a = mem_req_addr;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk(mem_req_valid && mem_req_addr == a, "R8 request held", mem_req_addr, a);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(!mem_req_valid, "R8 single outstanding read", 32'(mem_req_valid), 32'h0);
      repeat (lat) @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_val(a);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hDEAD_BEEF;
   endtask

   task automatic walk(input logic [31:0] va, input int lat, input int stall, input bit poke);
      int o = int'(va[31:20]);
      int i = int'(va[19:10]);
      logic [31:0] oaddr = PTBR0 + 32'(o) * 4;
      logic [31:0] iaddr = INNER + 32'(o) * 4096 + 32'(i) * 4;
      logic [31:0] exp_pa;
      bit exp_f, exp_l, extra;
      int n;
      exp_f  = !outer_ok(o) || !inner_ok(o, i);
      exp_l  = outer_ok(o) && !inner_ok(o, i);
      exp_pa = exp_f ? 32'h0 : {frame_of(o, i), va[9:0]};

      @(negedge clk);
      chk(req_ready, "R10 idle accepts", 32'(req_ready), 32'h1);
      req_valid = 1'b1; req_vaddr = va; ptbr = PTBR0;
      @(negedge clk);
      if (poke) begin
         req_vaddr = ~va; ptbr = PTBR1;   // R3/R10: must not disturb the walk
      end else begin
         req_valid = 1'b0;
      end
      serve(oaddr, lat, stall, poke, "R3 outer entry address");
      if (outer_ok(o)) serve(iaddr, (lat + 1) % 4, stall, poke, "R4 inner entry address");
      n = 0; extra = 1'b0;
      while (!rsp_valid && n < 12) begin
         if (mem_req_valid) extra = 1'b1;
         @(negedge clk); n++;
      end
      chk(!extra, "R6 no read after outer fault", 32'(extra), 32'h0);
      chk(rsp_valid, "R9 result presented", 32'(rsp_valid), 32'h1);
      chk(rsp_fault == exp_f, exp_l ? "R7 inner fault flag" : "R6 fault flag", 32'(rsp_fault), 32'(exp_f));
      if (exp_f)
         chk(rsp_fault_level == exp_l, exp_l ? "R7 fault level" : "R6 fault level",
             32'(rsp_fault_level), 32'(exp_l));
      chk(rsp_paddr == exp_pa, exp_f ? "R6 R7 zero address" : "R5 R2 physical address",
          rsp_paddr, exp_pa);
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == exp_pa && rsp_fault == exp_f, "R9 result held", rsp_paddr, exp_pa);
      if (poke) begin
         chk(!req_ready, "R10 no accept while result pending", 32'(req_ready), 32'h0);
         req_valid = 1'b0;
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && req_ready, "R9 back to idle after ack", {30'h0, rsp_valid, req_ready}, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int outs[12] = '{0, 1, 2, 3, 4, 7, 8, 13, 100, 2047, 4094, 4095};
      int ins[8]   = '{0, 1, 2, 6, 7, 511, 1022, 1023};
      repeat (3) @(negedge clk);
      chk(req_ready && !mem_req_valid && !rsp_valid, "R1 reset state",
          {29'h0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !mem_req_valid && !rsp_valid, "R1 idle after reset",
          {29'h0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

      // R11: stray response while idle
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'h4000_0001;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req_valid, "R11 stray response ignored",
          {29'h0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

      foreach (outs[a]) begin
         foreach (ins[b]) begin
            logic [9:0] off = 10'((outs[a] * 37 + ins[b] * 11) & 1023);
            walk({12'(outs[a]), 10'(ins[b]), off}, (outs[a] + ins[b]) % 4, ins[b] % 3, ins[b] == 7);
         end
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule